// File: doc/BRIEF.md
# Host Byte Port for a DSP Data and Status Register

This block sits between an 8-bit host bus and the 16-bit data register and 16-bit status register of a signal processor. A host access is a one-cycle strobe with a select bit. With the select bit low, the access reaches the status register: a read returns the upper status byte and a write is dropped. With the select bit high, the access reaches the data register one byte at a time.

A mode bit held in the status register picks the host transfer width at run time. In 16-bit mode a phase bit steps the host through the low byte and then the high byte. The request flag clears only after the high byte. In 8-bit mode every data access uses the low byte and clears the request flag straight away. On the processor side the core can load the data register, which raises the request flag. It can read the data register either with a strobe that raises the request flag or with a plain strobe that leaves the flag alone. It can load the status register, where a fixed keep-mask protects the handshake bits. Two general-purpose output pins follow the two lowest status bits.

The host port never applies back-pressure. Every strobe is accepted in the cycle it is presented. Read data is combinational from the current state while the strobe is high, and the state update from that access lands at the closing clock edge. Core strobes are likewise accepted in every cycle.

Top module: `hdp_port`

## Requirements
- R1: Reset (active-low `rst_n`) clears the status register, the data register and both general-purpose pins. After reset a host status read returns 0x00.
- R2: A host read with `host_sel_data`=0 returns status bits [15:8]. In that byte, bit 7 is the request flag (status bit 15), bit 4 is the byte phase (status bit 12) and bit 2 is the width mode (status bit 10).
- R3: With width mode 0 (16-bit) and phase 0, a host data access transfers data register bits [7:0] and sets the phase to 1.
- R4: With width mode 0 and phase 1, a host data access transfers data register bits [15:8], clears the phase and clears the request flag.
- R5: With width mode 1 (8-bit), every host data access transfers data register bits [7:0], clears the request flag and leaves the phase unchanged.
- R6: A host data write replaces only the byte that the current access addresses. The other byte of the data register keeps its value.
- R7: A core data load (`core_dr_load`) writes all 16 bits of the data register and sets the request flag.
- R8: A core read with `core_rd_flag`=1 sets the request flag. A core read with `core_rd_flag`=0 leaves the request flag unchanged.
- R9: A core status load keeps the status bits selected by mask 0x907C (request flag, phase and bits 6..2) and takes every other bit from `core_sr_wdata`.
- R10: `gpo0` equals status bit 0 and `gpo1` equals status bit 1. Both follow every status load and reset.
- R11: A host write with `host_sel_data`=0 changes neither the status register nor the data register.
- R12: When a core update and a host access fall in the same cycle, the core wins. A core set of the request flag beats a host clear, and a core data load beats a host byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stb | input | 1 | One-cycle host access strobe |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_sel_data | input | 1 | 1 = data register, 0 = status register |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid while the strobe is high |
| core_dr_load | input | 1 | Core loads the data register |
| core_dr_wdata | input | 16 | Core data register value |
| core_rd | input | 1 | Core read strobe of the data register |
| core_rd_flag | input | 1 | Core read also sets the request flag |
| core_dr | output | 16 | Current data register |
| core_sr_load | input | 1 | Core masked status load |
| core_sr_wdata | input | 16 | Core status value |
| core_sr | output | 16 | Current status register |
| gpo0 | output | 1 | General-purpose pin from status bit 0 |
| gpo1 | output | 1 | General-purpose pin from status bit 1 |

## Verification
Host read data is combinational, so the bench samples it 1 ns after it drives the strobe on the falling edge, before the rising edge that applies the access. Every register effect (phase, request flag, data bytes, status load, pins) appears one rising edge after the strobe. The bench reads those effects at the next falling edge, either through a status read or through `core_sr`, `core_dr` and the pins. The same-cycle conflict cases drive host and core strobes on the same falling edge and then check the single edge that follows.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
  localparam int SR_RQM = 15;
  localparam int SR_DRS = 12;
  localparam int SR_DRC = 10;
  localparam int SR_P1  = 1;
  localparam int SR_P0  = 0;

  typedef struct packed {
    logic hi_byte;
    logic drs_set;
    logic drs_clr;
    logic rqm_clr;
  } hdp_phase_t;
endpackage

// File: rtl/hdp_phase_ctrl.sv
module hdp_phase_ctrl
  import hdp_pkg::*;
(
  input  logic       data_acc,
  input  logic       mode8,
  input  logic       phase,
  output hdp_phase_t ph
);
  always_comb begin
    ph = '0;
    ph.hi_byte = ~mode8 & phase;
    if (data_acc) begin
      if (mode8) begin
        ph.rqm_clr = 1'b1;
      end else if (!phase) begin
        ph.drs_set = 1'b1;
      end else begin
        ph.drs_clr = 1'b1;
        ph.rqm_clr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdp_data_reg.sv
module hdp_data_reg #(
  parameter int HOST_W = 8,
  localparam int DR_W = 2 * HOST_W,
  localparam int NLANE = DR_W / HOST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_load,
  input  logic [DR_W-1:0]   core_wdata,
  input  logic              host_wr,
  input  logic              host_hi,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [DR_W-1:0]   dr
);
  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    logic lane_hit;
    assign lane_hit = host_wr && (host_hi == (b != 0));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dr[b*HOST_W +: HOST_W] <= '0;
      end else if (core_load) begin
        dr[b*HOST_W +: HOST_W] <= core_wdata[b*HOST_W +: HOST_W];
      end else if (lane_hit) begin
        dr[b*HOST_W +: HOST_W] <= host_wdata;
      end
    end
  end

  // R6: a low-byte host write leaves the high byte alone
  p_low_write_keeps_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_hi && !core_load |=> dr[DR_W-1:HOST_W] == $past(dr[DR_W-1:HOST_W]));
  // R6: a high-byte host write leaves the low byte alone
  p_high_write_keeps_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_hi && !core_load |=> dr[HOST_W-1:0] == $past(dr[HOST_W-1:0]));
  // R7 / R12: a core load takes the whole word, even against a host write
  p_core_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |=> dr == $past(core_wdata));
endmodule

// File: rtl/hdp_status_reg.sv
module hdp_status_reg
  import hdp_pkg::*;
#(
  parameter int SR_W = 16,
  parameter logic [SR_W-1:0] KEEP_MASK = 16'h907C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_load,
  input  logic [SR_W-1:0] core_wdata,
  input  logic            rqm_set,
  input  logic            rqm_clr,
  input  logic            drs_set,
  input  logic            drs_clr,
  output logic [SR_W-1:0] sr
);
  logic [SR_W-1:0] base;
  logic [SR_W-1:0] sr_nxt;

  always_comb begin
    base = core_load ? ((sr & KEEP_MASK) | (core_wdata & ~KEEP_MASK)) : sr;
    sr_nxt = base;
    if (drs_set)      sr_nxt[SR_DRS] = 1'b1;
    else if (drs_clr) sr_nxt[SR_DRS] = 1'b0;
    if (rqm_set)      sr_nxt[SR_RQM] = 1'b1;
    else if (rqm_clr) sr_nxt[SR_RQM] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_nxt;
  end

  // R9: bits outside the keep-mask come from the core word
  p_masked_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |=> (sr & ~KEEP_MASK) == ($past(core_wdata) & ~KEEP_MASK));
  // R9: kept bits outside the handshake pair never move
  p_kept_bits_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sr[6:2] == $past(sr[6:2]));
  // R12: a core set beats a host clear in the same cycle
  p_core_rqm_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rqm_set |=> sr[SR_RQM]);
  // R3: phase set leads to phase 1
  p_phase_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drs_set |=> sr[SR_DRS]);
endmodule

// File: rtl/hdp_port.sv
module hdp_port
  import hdp_pkg::*;
#(
  parameter int HOST_W = 8,
  parameter logic [2*HOST_W-1:0] SR_KEEP_MASK = 16'h907C,
  localparam int DR_W = 2 * HOST_W,
  localparam int SR_W = DR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_stb,
  input  logic              host_we,
  input  logic              host_sel_data,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              core_dr_load,
  input  logic [DR_W-1:0]   core_dr_wdata,
  input  logic              core_rd,
  input  logic              core_rd_flag,
  output logic [DR_W-1:0]   core_dr,
  input  logic              core_sr_load,
  input  logic [SR_W-1:0]   core_sr_wdata,
  output logic [SR_W-1:0]   core_sr,
  output logic              gpo0,
  output logic              gpo1
);
  hdp_phase_t ph;
  logic data_acc;
  logic rqm_set;
  logic [DR_W-1:0] dr_q;
  logic [SR_W-1:0] sr_q;

  assign data_acc = host_stb & host_sel_data;
  assign rqm_set  = core_dr_load | (core_rd & core_rd_flag);

  hdp_phase_ctrl u_phase (
    .data_acc (data_acc),
    .mode8    (sr_q[SR_DRC]),
    .phase    (sr_q[SR_DRS]),
    .ph       (ph)
  );

  hdp_data_reg #(.HOST_W(HOST_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_load  (core_dr_load),
    .core_wdata (core_dr_wdata),
    .host_wr    (data_acc & host_we),
    .host_hi    (ph.hi_byte),
    .host_wdata (host_wdata),
    .dr         (dr_q)
  );

  hdp_status_reg #(.SR_W(SR_W), .KEEP_MASK(SR_KEEP_MASK)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_load  (core_sr_load),
    .core_wdata (core_sr_wdata),
    .rqm_set    (rqm_set),
    .rqm_clr    (ph.rqm_clr),
    .drs_set    (ph.drs_set),
    .drs_clr    (ph.drs_clr),
    .sr         (sr_q)
  );

  always_comb begin
    if (!host_sel_data)   host_rdata = sr_q[SR_W-1 -: HOST_W];
    else if (ph.hi_byte)  host_rdata = dr_q[DR_W-1 -: HOST_W];
    else                  host_rdata = dr_q[HOST_W-1:0];
  end

  assign core_dr = dr_q;
  assign core_sr = sr_q;
  assign gpo0    = sr_q[SR_P0];
  assign gpo1    = sr_q[SR_P1];

  // R4: the second 16-bit access clears phase and request
  p_second_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !core_sr[SR_DRC] && core_sr[SR_DRS] && !rqm_set |=> !core_sr[SR_DRS] && !core_sr[SR_RQM]);
  // R5: 8-bit access clears request and keeps phase
  p_byte_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && core_sr[SR_DRC] && !rqm_set |=> !core_sr[SR_RQM] && $stable(core_sr[SR_DRS]));
  // R7: a core load raises the request flag
  p_load_sets_rqm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_dr_load |=> core_sr[SR_RQM]);
  // R8: a plain core read alone leaves the request flag
  p_plain_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd && !core_rd_flag && !core_dr_load && !data_acc |=> $stable(core_sr[SR_RQM]));
  // R10: pins take the loaded bits
  p_pins_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_sr_load |=> gpo0 == $past(core_sr_wdata[SR_P0]) && gpo1 == $past(core_sr_wdata[SR_P1]));
  // R11: host status writes change nothing
  p_status_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_stb && host_we && !host_sel_data && !core_dr_load && !core_rd && !core_sr_load
    |=> $stable(core_sr) && $stable(core_dr));
endmodule

// File: tb/hdp_port_tb.sv
module hdp_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_stb = 0, host_we = 0, host_sel_data = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic core_dr_load = 0, core_rd = 0, core_rd_flag = 0, core_sr_load = 0;
  logic [15:0] core_dr_wdata = '0, core_sr_wdata = '0;
  logic [15:0] core_dr, core_sr;
  logic gpo0, gpo1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hdp_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_we(host_we),
    .host_sel_data(host_sel_data), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_dr_load(core_dr_load), .core_dr_wdata(core_dr_wdata), .core_rd(core_rd),
    .core_rd_flag(core_rd_flag), .core_dr(core_dr), .core_sr_load(core_sr_load),
    .core_sr_wdata(core_sr_wdata), .core_sr(core_sr), .gpo0(gpo0), .gpo1(gpo1)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    host_stb = 0; host_we = 0; core_dr_load = 0; core_rd = 0; core_rd_flag = 0; core_sr_load = 0;
  endtask

  // drive at falling edge, sample read data 1 ns later, release after the rising edge
  task automatic host(input logic we, input logic sel, input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    host_stb = 1; host_we = we; host_sel_data = sel; host_wdata = wd;
    #1 rd = host_rdata;
    @(posedge clk); #1 idle_all();
  endtask

  task automatic status_is(string tag, logic [7:0] exp);
    logic [7:0] r;
    host(0, 0, 8'h00, r);
    chk(tag, {8'h00, r}, {8'h00, exp});
  endtask

  task automatic core_load_dr(input logic [15:0] v);
    @(negedge clk); core_dr_load = 1; core_dr_wdata = v;
    @(posedge clk); #1 idle_all();
  endtask

  task automatic core_load_sr(input logic [15:0] v);
    @(negedge clk); core_sr_load = 1; core_sr_wdata = v;
    @(posedge clk); #1 idle_all();
  endtask

  task automatic core_read(input logic flag);
    @(negedge clk); core_rd = 1; core_rd_flag = flag;
    @(posedge clk); #1 idle_all();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 sr", core_sr, 16'h0000);
    chk("R1 dr", core_dr, 16'h0000);
    chk("R1 pins", {14'h0, gpo1, gpo0}, 16'h0000);
    status_is("R1 status read", 8'h00);
  endtask

  task automatic t_sixteen_read();
    logic [7:0] r;
    core_load_dr(16'hA55A);
    @(negedge clk); chk("R7 dr loaded", core_dr, 16'hA55A);
    status_is("R7 rqm set / R2 layout", 8'h80);
    host(0, 1, 8'h00, r); chk("R3 low byte", {8'h0, r}, 16'h005A);
    status_is("R3 phase set", 8'h90);
    host(0, 1, 8'h00, r); chk("R4 high byte", {8'h0, r}, 16'h00A5);
    status_is("R4 phase and rqm clear", 8'h00);
  endtask

  task automatic t_sixteen_write();
    logic [7:0] r;
    core_load_dr(16'h1234);
    host(1, 1, 8'hCD, r);
    @(negedge clk); chk("R6 low byte write", core_dr, 16'h12CD);
    status_is("R3 phase after write", 8'h90);
    host(1, 1, 8'hEF, r);
    @(negedge clk); chk("R6 high byte write", core_dr, 16'hEFCD);
    status_is("R4 rqm clear after write", 8'h00);
  endtask

  task automatic t_conflict();
    logic [7:0] r;
    core_load_dr(16'h1111);
    host(0, 1, 8'h00, r); chk("R3 low byte", {8'h0, r}, 16'h0011);
    @(negedge clk);
    host_stb = 1; host_we = 1; host_sel_data = 1; host_wdata = 8'h77;
    core_dr_load = 1; core_dr_wdata = 16'h2222;
    @(posedge clk); #1 idle_all();
    @(negedge clk); chk("R12 core data wins", core_dr, 16'h2222);
    status_is("R12 core rqm wins, phase cleared", 8'h80);
  endtask

  task automatic t_status_write();
    logic [7:0] r;
    host(1, 0, 8'hFF, r);
    @(negedge clk);
    chk("R11 sr unchanged", core_sr, 16'h8000);
    chk("R11 dr unchanged", core_dr, 16'h2222);
  endtask

  task automatic t_core_read();
    logic [7:0] r;
    host(0, 1, 8'h00, r);
    host(0, 1, 8'h00, r);
    core_read(0);
    @(negedge clk); chk("R8 plain read keeps rqm", core_sr, 16'h0000);
    core_read(1);
    @(negedge clk); chk("R8 flagged read sets rqm", core_sr, 16'h8000);
  endtask

  task automatic t_eight_bit();
    logic [7:0] r;
    core_load_sr(16'h0400);
    status_is("R9 mode bit loaded, rqm kept", 8'h84);
    host(0, 1, 8'h00, r); chk("R5 low byte", {8'h0, r}, 16'h0022);
    status_is("R5 rqm clear, phase 0", 8'h04);
    core_load_dr(16'h5678);
    host(1, 1, 8'h9A, r);
    @(negedge clk); chk("R5 low byte write", core_dr, 16'h569A);
    status_is("R5 rqm clear after write", 8'h04);
  endtask

  task automatic t_mask();
    logic [7:0] r;
    core_load_sr(16'hFFFF);
    @(negedge clk); chk("R9 masked load", core_sr, 16'h6F83);
    chk("R10 pins high", {14'h0, gpo1, gpo0}, 16'h0003);
    core_load_dr(16'h0000);
    core_load_sr(16'h0001);
    @(negedge clk); chk("R9 rqm kept", core_sr, 16'h8001);
    chk("R10 pins follow", {14'h0, gpo1, gpo0}, 16'h0001);
    core_load_sr(16'h0000);
    host(0, 1, 8'h00, r);
    core_load_sr(16'h0000);
    @(negedge clk); chk("R9 phase kept", core_sr, 16'h9000);
  endtask

  initial begin
    t_reset();
    t_sixteen_read();
    t_sixteen_write();
    t_conflict();
    t_status_write();
    t_core_read();
    t_eight_bit();
    t_mask();
    core_load_sr(16'h0003);
    do_reset();
    @(negedge clk);
    chk("R1 mid-run reset sr", core_sr, 16'h0000);
    chk("R1 mid-run reset pins", {14'h0, gpo1, gpo0}, 16'h0000);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule